// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits between a system and an asynchronous parallel flash device that takes unlock command sequences. It accepts one operation at a time over a valid/ready handshake. The operation is a byte program (target address and data), a sector erase (sector address) or a full chip erase. The block plays the required command writes onto a clocked model of the flash pins, using a write strobe with configurable low and high widths. It then reads the device repeatedly until the internal operation has finished, and reports completion with a one-cycle done pulse.

Completion is detected in one of two ways, chosen for each request. In the first, bit 7 of the polled byte is compared with the bit the device should end up holding. In the second, the block watches for bit 6 to read the same value twice in a row. Each operation kind has its own cycle budget for polling. When that budget runs out, the block writes the read-mode command to the device and then signals done together with an error flag.

Top module: `flash_seq`

## Requirements
- R1: When idle, `req_ready_o` is 1, and a request is taken in the cycle where `req_valid_i` and `req_ready_o` are both 1. From the next cycle on, `req_ready_o` stays 0, and `req_valid_i` is ignored until the cycle that carries the done pulse.
- R2: When `req_op_i` is 00 (program), the writes issued are, in order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then `req_addr_i`/`req_data_i`.
- R3: When `req_op_i` is 01 (sector erase), the writes issued are, in order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then `req_addr_i`/30h.
- R4: When `req_op_i` is 10 or 11 (chip erase), the write sequence is the same as for a sector erase, except that the last write is 5555h/10h.
- R5: Each write holds `fl_we_no` low for exactly WR_LOW_CYC cycles. Between two writes, `fl_we_no` stays high for at least HIGH_CYC cycles. Address and write data are stable while the strobe is low. `fl_we_no` and `fl_oe_no` are never low at the same time.
- R6: Polling reads always use `req_addr_i`. With `req_toggle_i` = 0, the operation completes on the first read whose bit 7 equals the expected bit. That bit is `req_data_i[7]` for a program and 1 for either erase.
- R7: With `req_toggle_i` = 1, the operation completes on the first read whose bit 6 equals bit 6 of the read before it. The first read of an operation can never complete it.
- R8: Polling gives up after PROG_TMO_CYC, SECT_TMO_CYC or CHIP_TMO_CYC cycles, depending on the operation kind. After the last read that fails, the block issues one write of 5555h/F0h, then pulses done with the error flag set.
- R9: `done_o` is a single-cycle pulse. `err_o` is 1 only in a cycle where `done_o` is 1, and it is 0 when polling succeeded.
- R10: After reset, `req_ready_o` = 1, `fl_we_no` = 1, `fl_oe_no` = 1, `done_o` = 0 and `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr_i | input | AW | Target, sector or poll address |
| req_data_i | input | 8 | Byte to program |
| req_toggle_i | input | 1 | 1 selects bit-6 toggle polling, 0 selects bit-7 compare |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| err_o | output | 1 | Polling timed out (only with done_o) |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data |
| fl_we_no | output | 1 | Write strobe, active low |
| fl_oe_no | output | 1 | Read strobe, active low |

## Verification
The inline assertions check the pin-level rules on every cycle:
- the exact strobe-low width and the minimum high gap, both measured by independent run counters;
- address and data stability during a write;
- mutual exclusion of the two strobes;
- the ready drop around writes;
- done and error pulse shape.

Only the bench scenarios can show that the sequencer behaves correctly against a device model:
- each operation kind produces the right command sequence;
- each polling mode stops on exactly the right read count for several busy lengths;
- the timeout path issues the read-mode write;
- a request raised mid-operation is ignored.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {K_PROG, K_SECT, K_CHIP} kind_e;
  typedef enum logic [1:0] {T_IDLE, T_CMD, T_POLL, T_ABORT} top_st_e;
  typedef enum logic [1:0] {B_IDLE, B_STROBE, B_RECOV} bus_st_e;

  localparam logic [15:0] UNLK_A_ADDR = 16'h5555;
  localparam logic [15:0] UNLK_B_ADDR = 16'h2AAA;
  localparam logic [7:0]  UNLK_A_DAT  = 8'hAA;
  localparam logic [7:0]  UNLK_B_DAT  = 8'h55;
  localparam logic [7:0]  PROG_DAT    = 8'hA0;
  localparam logic [7:0]  ERASE_DAT   = 8'h80;
  localparam logic [7:0]  CHIP_DAT    = 8'h10;
  localparam logic [7:0]  SECT_DAT    = 8'h30;
  localparam logic [7:0]  RDMODE_DAT  = 8'hF0;

  function automatic kind_e decode_op(input logic [1:0] op);
    if (op[1])      return K_CHIP;
    else if (op[0]) return K_SECT;
    else            return K_PROG;
  endfunction
endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  kind_e          kind_i,
  input  logic [2:0]     step_i,
  input  logic [AW-1:0]  tgt_addr_i,
  input  logic [7:0]     tgt_data_i,
  output logic [AW-1:0]  addr_o,
  output logic [7:0]     data_o,
  output logic           last_o
);
  localparam logic [AW-1:0] A_ADDR = AW'(UNLK_A_ADDR);
  localparam logic [AW-1:0] B_ADDR = AW'(UNLK_B_ADDR);

  always_comb begin
    addr_o = A_ADDR;
    data_o = UNLK_A_DAT;
    last_o = 1'b0;
    unique case (step_i)
      3'd0: ;
      3'd1: begin addr_o = B_ADDR; data_o = UNLK_B_DAT; end
      3'd2: data_o = (kind_i == K_PROG) ? PROG_DAT : ERASE_DAT;
      3'd3: begin
        if (kind_i == K_PROG) begin
          addr_o = tgt_addr_i;
          data_o = tgt_data_i;
          last_o = 1'b1;
        end
      end
      3'd4: begin addr_o = B_ADDR; data_o = UNLK_B_DAT; end
      default: begin
        last_o = 1'b1;
        if (kind_i == K_CHIP) data_o = CHIP_DAT;
        else begin
          addr_o = tgt_addr_i;
          data_o = SECT_DAT;
        end
      end
    endcase
  end
endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval (
  input  logic       toggle_i,
  input  logic       exp7_i,
  input  logic [1:0] rd76_i,
  input  logic       prev6_i,
  input  logic       have_prev_i,
  output logic       complete_o
);
  always_comb begin
    if (toggle_i) complete_o = have_prev_i && (rd76_i[0] == prev6_i);
    else          complete_o = (rd76_i[1] == exp7_i);
  end
endmodule

// File: rtl/fseq_bus.sv
module fseq_bus
  import flash_seq_pkg::*;
#(
  parameter int AW         = 19,
  parameter int WR_LOW_CYC = 4,
  parameter int HIGH_CYC   = 2,
  parameter int RD_CYC     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    rd76_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  input  logic [7:0]    fl_rdata_i,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int MAXC = (WR_LOW_CYC > HIGH_CYC)
                        ? ((WR_LOW_CYC > RD_CYC) ? WR_LOW_CYC : RD_CYC)
                        : ((HIGH_CYC > RD_CYC) ? HIGH_CYC : RD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(WR_LOW_CYC - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] HI_LAST  = CW'(HIGH_CYC - 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [CW-1:0] stb_last;
  logic          unused_rbits;

  assign unused_rbits = ^fl_rdata_i[5:0];
  assign stb_last     = rd_q ? RD_LAST : LOW_LAST;
  assign busy_o       = (st_q != B_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= B_IDLE;
      cnt_q      <= '0;
      rd_q       <= 1'b0;
      done_o     <= 1'b0;
      rd76_o     <= '0;
      fl_addr_o  <= '0;
      fl_wdata_o <= '0;
      fl_we_no   <= 1'b1;
      fl_oe_no   <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        B_IDLE: if (start_i) begin
          st_q       <= B_STROBE;
          cnt_q      <= '0;
          rd_q       <= rd_i;
          fl_addr_o  <= addr_i;
          fl_wdata_o <= rd_i ? 8'h00 : wdata_i;
          fl_we_no   <= rd_i;
          fl_oe_no   <= !rd_i;
        end
        B_STROBE: begin
          if (cnt_q == stb_last) begin
            if (rd_q) rd76_o <= fl_rdata_i[7:6];
            fl_we_no <= 1'b1;
            fl_oe_no <= 1'b1;
            cnt_q    <= '0;
            st_q     <= B_RECOV;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        B_RECOV: begin
          if (cnt_q == HI_LAST) begin
            st_q   <= B_IDLE;
            done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  // independent strobe run counters for the timing checks
  logic [CW-1:0] low_run_q, high_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= CW'(HIGH_CYC);
    end else if (!fl_we_no) begin
      low_run_q  <= (low_run_q == CW'(MAXC)) ? low_run_q : low_run_q + 1'b1;
      high_run_q <= '0;
    end else begin
      low_run_q  <= '0;
      high_run_q <= (high_run_q >= CW'(HIGH_CYC)) ? high_run_q : high_run_q + 1'b1;
    end
  end

  a_r5_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (low_run_q == CW'(WR_LOW_CYC)));
  a_r5_high_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_we_no) |-> (high_run_q >= CW'(HIGH_CYC)));
  a_r5_stable_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));
  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW           = 19,
  parameter int WR_LOW_CYC   = 4,
  parameter int HIGH_CYC     = 2,
  parameter int RD_CYC       = 4,
  parameter int PROG_TMO_CYC = 1000,
  parameter int SECT_TMO_CYC = 500000,
  parameter int CHIP_TMO_CYC = 150000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  input  logic          req_toggle_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  input  logic [7:0]    fl_rdata_i,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int TMO_MAX = (PROG_TMO_CYC > SECT_TMO_CYC)
                           ? ((PROG_TMO_CYC > CHIP_TMO_CYC) ? PROG_TMO_CYC : CHIP_TMO_CYC)
                           : ((SECT_TMO_CYC > CHIP_TMO_CYC) ? SECT_TMO_CYC : CHIP_TMO_CYC);
  localparam int TW = $clog2(TMO_MAX + 1);

  top_st_e       st_q;
  kind_e         kind_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          tog_q;
  logic [2:0]    step_q;
  logic [TW-1:0] tmr_q;
  logic          have_prev_q, prev6_q;

  logic [AW-1:0] t_addr;
  logic [7:0]    t_data;
  logic          t_last;
  logic          b_start, b_rd, b_busy, b_done;
  logic [AW-1:0] b_addr;
  logic [7:0]    b_wdata;
  logic [1:0]    b_rd76;
  logic          complete;
  logic          exp7;
  logic [TW-1:0] tmo_lim;

  assign req_ready_o = (st_q == T_IDLE);
  assign exp7        = (kind_q == K_PROG) ? data_q[7] : 1'b1;

  always_comb begin
    unique case (kind_q)
      K_PROG:  tmo_lim = TW'(PROG_TMO_CYC);
      K_SECT:  tmo_lim = TW'(SECT_TMO_CYC);
      default: tmo_lim = TW'(CHIP_TMO_CYC);
    endcase
  end

  fseq_cmd_table #(.AW(AW)) u_tbl (
    .kind_i(kind_q), .step_i(step_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .addr_o(t_addr), .data_o(t_data), .last_o(t_last)
  );

  fseq_poll_eval u_eval (
    .toggle_i(tog_q), .exp7_i(exp7), .rd76_i(b_rd76), .prev6_i(prev6_q),
    .have_prev_i(have_prev_q), .complete_o(complete)
  );

  assign b_start = (st_q != T_IDLE) && !b_busy && !b_done;

  always_comb begin
    b_rd    = 1'b0;
    b_addr  = t_addr;
    b_wdata = t_data;
    unique case (st_q)
      T_POLL: begin
        b_rd    = 1'b1;
        b_addr  = addr_q;
        b_wdata = 8'h00;
      end
      T_ABORT: begin
        b_addr  = AW'(UNLK_A_ADDR);
        b_wdata = RDMODE_DAT;
      end
      default: ;
    endcase
  end

  fseq_bus #(
    .AW(AW), .WR_LOW_CYC(WR_LOW_CYC), .HIGH_CYC(HIGH_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(b_start), .rd_i(b_rd),
    .addr_i(b_addr), .wdata_i(b_wdata), .busy_o(b_busy), .done_o(b_done),
    .rd76_o(b_rd76), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
    .fl_rdata_i(fl_rdata_i), .fl_we_no(fl_we_no), .fl_oe_no(fl_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= T_IDLE;
      kind_q      <= K_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      tog_q       <= 1'b0;
      step_q      <= '0;
      tmr_q       <= '0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st_q)
        T_IDLE: if (req_valid_i) begin
          kind_q <= decode_op(req_op_i);
          addr_q <= req_addr_i;
          data_q <= req_data_i;
          tog_q  <= req_toggle_i;
          step_q <= '0;
          st_q   <= T_CMD;
        end
        T_CMD: if (b_done) begin
          if (t_last) begin
            st_q        <= T_POLL;
            tmr_q       <= '0;
            have_prev_q <= 1'b0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        T_POLL: begin
          if (tmr_q < tmo_lim) tmr_q <= tmr_q + 1'b1;
          if (b_done) begin
            prev6_q     <= b_rd76[0];
            have_prev_q <= 1'b1;
            if (complete) begin
              done_o <= 1'b1;
              st_q   <= T_IDLE;
            end else if (tmr_q >= tmo_lim) begin
              st_q <= T_ABORT;
            end
          end
        end
        T_ABORT: if (b_done) begin
          done_o <= 1'b1;
          err_o  <= 1'b1;
          st_q   <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  a_r1_busy_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_we_no) |-> !req_ready_o);
  a_r1_accept_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_done_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW = 19, LOW = 3, HI = 2, RDC = 2;
  localparam int PT = 200, ST = 300, CT = 400;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic          tog;
    logic [15:0]   busy;
    logic          err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 19'h01234, 8'h5A, 1'b0, 16'd3,     1'b0},
    '{2'd0, 19'h7FFFF, 8'hC3, 1'b1, 16'd4,     1'b0},
    '{2'd0, 19'h00010, 8'h40, 1'b1, 16'd3,     1'b0},
    '{2'd1, 19'h12000, 8'h00, 1'b0, 16'd6,     1'b0},
    '{2'd2, 19'h00000, 8'h00, 1'b1, 16'd2,     1'b0},
    '{2'd0, 19'h00555, 8'h2B, 1'b1, 16'd0,     1'b0},
    '{2'd0, 19'h3C001, 8'h11, 1'b0, 16'd0,     1'b0},
    '{2'd0, 19'h00ABC, 8'h80, 1'b0, 16'd60000, 1'b1},
    '{2'd1, 19'h40000, 8'h00, 1'b1, 16'd60000, 1'b1},
    '{2'd3, 19'h00100, 8'h00, 1'b0, 16'd1,     1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_toggle_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [7:0] req_data_i = '0;
  logic req_ready_o, done_o, err_o, fl_we_no, fl_oe_no;
  logic [AW-1:0] fl_addr_o;
  logic [7:0] fl_wdata_o, fl_rdata_i;

  always #10 clk_i = ~clk_i;

  flash_seq #(
    .AW(AW), .WR_LOW_CYC(LOW), .HIGH_CYC(HI), .RD_CYC(RDC),
    .PROG_TMO_CYC(PT), .SECT_TMO_CYC(ST), .CHIP_TMO_CYC(CT)
  ) uut (.*);

  int total = 0, bad = 0, cyc = 0;
  int exp_nw = 0, nw = 0, busy = 0, cur_busy = 0, nrd = 0, rd_bad = 0, lowcnt = 0, wbad = 0;
  logic [7:0] fin = 8'hFF;
  logic [AW-1:0] exp_ra = '0;
  logic [AW-1:0] wa [8];
  logic [7:0] wd [8];

  always @(posedge clk_i) cyc++;
  always @(negedge clk_i) if (fl_we_no === 1'b0) lowcnt++;

  // device model
  always @(posedge fl_we_no) begin
    if (nw < 8) begin wa[nw] = fl_addr_o; wd[nw] = fl_wdata_o; end
    nw++;
    if (lowcnt != LOW) wbad++;
    lowcnt = 0;
    if (nw == exp_nw) begin busy = cur_busy; nrd = 0; end
  end
  always @(posedge fl_oe_no) begin
    nrd++;
    if (fl_addr_o !== exp_ra) rd_bad++;
    if (busy > 0) busy--;
  end
  always_comb begin
    if (busy > 0) fl_rdata_i = {~fin[7], ((nrd + 1) % 2) == 1, fin[5:0]};
    else          fl_rdata_i = fin;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_wr(input int kind, input int i, input vec_t v,
                                 output int a, output int d);
    a = 'h5555; d = 'hAA;
    if (i == 1 || i == 4) begin a = 'h2AAA; d = 'h55; end
    else if (i == 2) d = (kind == 0) ? 'hA0 : 'h80;
    else if (i == 3 && kind == 0) begin a = v.addr; d = v.data; end
    else if (i == 5) begin
      if (kind == 2) d = 'h10; else begin a = v.addr; d = 'h30; end
    end
  endfunction

  task automatic run(input vec_t v, input bit poke);
    int kind, len, exp_rd, t0, lim, n, a, d;
    kind = v.op[1] ? 2 : (v.op[0] ? 1 : 0);
    len  = (kind == 0) ? 4 : 6;
    lim  = (kind == 0) ? PT : ((kind == 1) ? ST : CT);
    fin  = (kind == 0) ? v.data : 8'hFF;
    if (v.tog) exp_rd = (v.busy == 0) ? 2 : ((v.busy[0] == fin[6]) ? v.busy + 1 : v.busy + 2);
    else       exp_rd = v.busy + 1;
    nw = 0; nrd = 0; busy = 0; rd_bad = 0; wbad = 0; lowcnt = 0;
    exp_nw = len; cur_busy = v.busy; exp_ra = v.addr;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = v.op; req_addr_i = v.addr;
    req_data_i = v.data; req_toggle_i = v.tog;
    @(posedge clk_i); t0 = cyc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R1 ready low after accept", req_ready_o, 0);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      req_valid_i = 1'b1; req_op_i = 2'd2; req_addr_i = '0;
      repeat (6) @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    n = 0;
    while (done_o !== 1'b1 && n < 30000) begin @(negedge clk_i); n++; end
    if (n >= 30000) begin
      chk(1'b0, "watchdog op hung", n, 0);
      return;
    end
    chk(err_o == v.err, "R8 R9 err flag", err_o, v.err);
    chk(nw == len + (v.err ? 1 : 0), "R2 R3 R4 R8 write count", nw, len + v.err);
    for (int i = 0; i < len && i < 8; i++) begin
      exp_wr(kind, i, v, a, d);
      chk(wa[i] == AW'(a) && wd[i] == 8'(d),
          (kind == 0) ? "R2 cmd write" : ((kind == 1) ? "R3 cmd write" : "R4 cmd write"),
          {wa[i], wd[i]}, {a[AW-1:0], d[7:0]});
    end
    if (v.err) begin
      chk(wa[len] == AW'('h5555) && wd[len] == 8'hF0, "R8 read-mode write",
          {wa[len], wd[len]}, {19'h5555, 8'hF0});
      chk(cyc - t0 >= lim, "R8 timeout not early", cyc - t0, lim);
    end else begin
      chk(nrd == exp_rd, v.tog ? "R7 toggle read count" : "R6 poll read count", nrd, exp_rd);
    end
    chk(rd_bad == 0, "R6 poll address", rd_bad, 0);
    chk(wbad == 0, "R5 strobe low width", wbad, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0 && err_o == 1'b0, "R9 done single pulse", {done_o, err_o}, 0);
    chk(req_ready_o == 1'b1, "R1 ready after done", req_ready_o, 1);
  endtask

  initial begin
    #(20ns * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(req_ready_o == 1 && fl_we_no == 1 && fl_oe_no == 1 && done_o == 0 && err_o == 0,
        "R10 reset state", {req_ready_o, fl_we_no, fl_oe_no, done_o, err_o}, 5'b11100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    for (int k = 0; k < NV; k++) run(VECS[k], 1'b0);
    // R1: request raised while busy is ignored
    run('{2'd0, 19'h05050, 8'hE7, 1'b0, 16'd2, 1'b0}, 1'b1);
    repeat (4) @(negedge clk_i);
    chk(nw == 4, "R1 mid-op request ignored", nw, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule